// File: doc/BRIEF.md
# Indirect Interrupt Controller Register Window

This block is the register file of an I/O interrupt controller. Software on a simple synchronous bus sees only two locations. One is a select register. The other is a data window. The select register chooses which internal word the window reaches. That word can be an identification word, a computed version word, an arbitration word that is fixed at zero, or one 32-bit half of a 64-bit redirection entry.

The whole redirection table is exported as a flat vector, so a downstream dispatcher can read any entry directly. Every bus access is a one-cycle strobe. The block answers it one clock later with a registered read word and a two-bit response code. The response is 0 for accepted, 1 for unsupported and 2 for invalid argument.

Top module: `intc_regwin`

## Requirements
- R1: A synchronous active-high reset sets the following to zero: the select value, the identification word, every redirection entry, `bus_rdata` and `bus_rsp`.
- R2: Only bus offset 0x00 (select) and bus offset 0x10 (window) are decoded. A read or write to any other offset answers with response 1 (unsupported), returns read data 0 and changes no state.
- R3: A write to the select register whose data is above 0xFF answers with response 2 (invalid) and leaves the select unchanged. A write of 0x00 to 0xFF is accepted. A read of offset 0x00 returns the select, zero-extended.
- R4: Window index 0x00 is a 32-bit identification word that can be both read and written.
- R5: Window index 0x01 reads as a version word. Bits 23:16 hold the entry count minus one, bits 7:0 hold 0x11, and all other bits are zero. With 24 entries the word is 0x00170011.
- R6: Window index 0x02 always reads as zero.
- R7: A window write to index 0x01 or 0x02 answers with response 0 and changes no state.
- R8: Window indices from 0x10 to 0x10+2·N−1 reach the redirection table. Entry number is (index−0x10)/2. An even index reaches bits 31:0 of the entry and an odd index reaches bits 63:32. Both halves can be read and written.
- R9: Any other window index (0x03–0x0F, or above the last table index) answers with response 1 on both read and write. It returns read data 0 and changes no state.
- R10: `bus_rdata` and `bus_rsp` update only on the clock edge that samples a strobe, and hold otherwise. A write strobe, or any strobe that is refused, returns read data 0.
- R11: Entry k of the table appears on `redir_tbl[64k+63:64k]`. A table write shows there on the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Bus offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rsp | output | 2 | Registered response: 0 ok, 1 unsupported, 2 invalid |
| redir_tbl | output | 64·NUM_ENT | Flat redirection table for the dispatcher |

## Verification
On every cycle, the assertions check the following. Responses hold between strobes. Writes return zero data. Undecoded offsets are refused. A select value that is too large leaves the select untouched. Writes to read-only or unsupported window indices leave the identification word and the table unchanged. Only the bench's sweeps can show the index arithmetic: that every table index reaches the right half of the right entry, that the exported vector has the same layout, and that the version word follows from the entry count.

// File: rtl/intc_regwin_pkg.sv
package intc_regwin_pkg;

    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_UNSUP = 2'd1,
        RSP_INVAL = 2'd2
    } rsp_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_SEL,
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_TBL
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [7:0] ent;
        logic       hi;
        rsp_e       rsp;
    } dec_t;

    localparam logic [7:0] IDX_ID   = 8'h00;
    localparam logic [7:0] IDX_VER  = 8'h01;
    localparam logic [7:0] IDX_ARB  = 8'h02;
    localparam logic [7:0] IDX_TBL0 = 8'h10;
    localparam logic [7:0] VER_CODE = 8'h11;

    function automatic logic [31:0] ver_word(input int n);
        return {8'h00, 8'(n - 1), 8'h00, VER_CODE};
    endfunction

    function automatic logic [7:0] last_tbl_idx(input int n);
        return 8'(16 + 2 * n - 1);
    endfunction

endpackage

// File: rtl/intc_regwin_sel.sv
module intc_regwin_sel (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_val,
    output logic [7:0] sel_q
);
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (wr_en)
            sel_q <= wr_val;
    end
endmodule

// File: rtl/intc_regwin_dec.sv
module intc_regwin_dec
    import intc_regwin_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_ENT = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    input  logic [7:0]        sel,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] OFF_SEL  = '0;
    localparam logic [ADDR_W-1:0] OFF_WIN  = ADDR_W'(16);
    localparam logic [7:0]        IDX_LAST = last_tbl_idx(NUM_ENT);

    always_comb begin
        dec.tgt = TGT_NONE;
        dec.ent = '0;
        dec.hi  = 1'b0;
        dec.rsp = RSP_UNSUP;
        if (addr == OFF_SEL) begin
            if (we && (wdata[31:8] != '0)) begin
                dec.rsp = RSP_INVAL;
            end else begin
                dec.tgt = TGT_SEL;
                dec.rsp = RSP_OK;
            end
        end else if (addr == OFF_WIN) begin
            dec.rsp = RSP_OK;
            if (sel == IDX_ID)
                dec.tgt = TGT_ID;
            else if (sel == IDX_VER)
                dec.tgt = TGT_VER;
            else if (sel == IDX_ARB)
                dec.tgt = TGT_ARB;
            else if ((sel >= IDX_TBL0) && (sel <= IDX_LAST)) begin
                dec.tgt = TGT_TBL;
                dec.ent = (sel - IDX_TBL0) >> 1;
                dec.hi  = sel[0];
            end else
                dec.rsp = RSP_UNSUP;
        end
    end
endmodule

// File: rtl/intc_regwin_tbl.sv
module intc_regwin_tbl #(
    parameter int NUM_ENT = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [7:0]           ent,
    input  logic                 hi,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic [NUM_ENT*64-1:0] tbl_o
);
    logic [31:0] lo_q [NUM_ENT];
    logic [31:0] hi_q [NUM_ENT];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_ENT; k++) begin
            if (rst) begin
                lo_q[k] <= '0;
                hi_q[k] <= '0;
            end else if (wr_en && (int'(ent) == k)) begin
                if (hi)
                    hi_q[k] <= wdata;
                else
                    lo_q[k] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_ENT; k++) begin
            if (int'(ent) == k)
                rdata = hi ? hi_q[k] : lo_q[k];
        end
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_exp
        assign tbl_o[g*64 +: 32]      = lo_q[g];
        assign tbl_o[g*64 + 32 +: 32] = hi_q[g];
    end

    // R8: a write never lands outside the table
    p_ent_range_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(ent) < NUM_ENT));
endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
    import intc_regwin_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_ENT = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [1:0]            bus_rsp,
    output logic [NUM_ENT*64-1:0] redir_tbl
);
    localparam logic [31:0]       VER_WORD = ver_word(NUM_ENT);
    localparam logic [7:0]        IDX_LAST = last_tbl_idx(NUM_ENT);
    localparam logic [ADDR_W-1:0] OFF_SEL  = '0;
    localparam logic [ADDR_W-1:0] OFF_WIN  = ADDR_W'(16);

    dec_t        dec;
    logic [7:0]  sel_q;
    logic [31:0] id_q;
    logic [31:0] tbl_rd;
    logic [31:0] rd_val;
    logic [31:0] rdata_q;
    rsp_e        rsp_q;
    logic        wr_sel, wr_id, wr_tbl;

    intc_regwin_dec #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) u_dec (
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .sel   (sel_q),
        .dec   (dec)
    );

    assign wr_sel = bus_req && bus_we && (dec.tgt == TGT_SEL);
    assign wr_id  = bus_req && bus_we && (dec.tgt == TGT_ID);
    assign wr_tbl = bus_req && bus_we && (dec.tgt == TGT_TBL);

    intc_regwin_sel u_sel (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_sel),
        .wr_val (bus_wdata[7:0]),
        .sel_q  (sel_q)
    );

    intc_regwin_tbl #(.NUM_ENT(NUM_ENT)) u_tbl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_tbl),
        .ent   (dec.ent),
        .hi    (dec.hi),
        .wdata (bus_wdata),
        .rdata (tbl_rd),
        .tbl_o (redir_tbl)
    );

    always_ff @(posedge clk) begin
        if (rst)
            id_q <= '0;
        else if (wr_id)
            id_q <= bus_wdata;
    end

    always_comb begin
        case (dec.tgt)
            TGT_SEL: rd_val = {24'h0, sel_q};
            TGT_ID:  rd_val = id_q;
            TGT_VER: rd_val = VER_WORD;
            TGT_TBL: rd_val = tbl_rd;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            rsp_q   <= RSP_OK;
        end else if (bus_req) begin
            rsp_q   <= dec.rsp;
            rdata_q <= (!bus_we && (dec.rsp == RSP_OK)) ? rd_val : '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_rsp   = rsp_q;

    // R10: response holds between strobes
    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> ($stable(bus_rdata) && $stable(bus_rsp)));

    // R10: writes return zero data
    p_wr_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |=> (bus_rdata == '0));

    // R2: undecoded bus offsets are refused
    p_bad_off_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && (bus_addr != OFF_SEL) && (bus_addr != OFF_WIN))
        |=> (bus_rsp == 2'd1));

    // R3: oversize select keeps the old select
    p_inval_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && (bus_addr == OFF_SEL) && (bus_wdata[31:8] != '0))
        |=> ($stable(sel_q) && (bus_rsp == 2'd2)));

    // R7: writes to read-only indices are accepted and discarded
    p_ro_write_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && (bus_addr == OFF_WIN) &&
         ((sel_q == IDX_VER) || (sel_q == IDX_ARB)))
        |=> ($stable(id_q) && $stable(redir_tbl) && (bus_rsp == 2'd0)));

    // R9: unsupported window indices change nothing
    p_unsup_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && (bus_addr == OFF_WIN) &&
         (((sel_q > IDX_ARB) && (sel_q < IDX_TBL0)) || (sel_q > IDX_LAST)))
        |=> ($stable(id_q) && $stable(redir_tbl) && (bus_rsp == 2'd1)));

    // R5: version read returns the computed word
    p_ver_read_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && (bus_addr == OFF_WIN) && (sel_q == IDX_VER))
        |=> (bus_rdata == VER_WORD));
endmodule

// File: tb/intc_regwin_test.sv
module intc_regwin_test;
    localparam int N  = 24;
    localparam int AW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [1:0]        bus_rsp;
    logic [N*64-1:0]   redir_tbl;

    int nchk = 0;
    int nerr = 0;

    logic [31:0] m_id;
    logic [7:0]  m_sel;
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];
    logic [31:0] r_data;
    logic [1:0]  r_rsp;

    always #2 clk = ~clk;

    intc_regwin #(.ADDR_W(AW), .NUM_ENT(N)) uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rsp(bus_rsp), .redir_tbl(redir_tbl)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        r_data = bus_rdata;
        r_rsp  = bus_rsp;
    endtask

    function automatic logic [31:0] pat(input int s);
        logic [7:0] b;
        b = 8'(s);
        return {b, ~b, b ^ 8'h5A, 8'hC3};
    endfunction

    function automatic logic [1:0] exp_rsp(input int s);
        if (s <= 2 || (s >= 16 && s < 16 + 2 * N)) return 2'd0;
        return 2'd1;
    endfunction

    function automatic logic [31:0] exp_win(input int s);
        if (s == 0) return m_id;
        if (s == 1) return (32'(N - 1) << 16) | 32'h11;
        if (s == 2) return 32'h0;
        if (s >= 16 && s < 16 + 2 * N)
            return ((s - 16) % 2 == 1) ? m_hi[(s - 16) / 2] : m_lo[(s - 16) / 2];
        return 32'h0;
    endfunction

    task automatic chk_tbl(input string tag);
        logic [N*64-1:0] e;
        for (int k = 0; k < N; k++) e[k*64 +: 64] = {m_hi[k], m_lo[k]};
        nchk++;
        if (redir_tbl !== e) begin
            nerr++;
            $display("FAIL %s table export actual=%0h expected=%0h", tag, redir_tbl, e);
        end
    endtask

    task automatic model_clear();
        m_id = '0; m_sel = '0;
        for (int k = 0; k < N; k++) begin m_lo[k] = '0; m_hi[k] = '0; end
    endtask

    initial begin
        #600000;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 rsp", bus_rsp, 0);
        chk_tbl("R1");
        access(1'b0, 8'h00, 0);
        chk("R1 select", r_data, 0);
        access(1'b0, 8'h10, 0);
        chk("R1 id", r_data, 0);

        // R2: all undecoded offsets, read and write
        for (int a = 0; a < 256; a++) begin
            if (a == 0 || a == 16) continue;
            access(1'b0, AW'(a), 0);
            chk("R2 read rsp", r_rsp, 1);
            chk("R2 read data", r_data, 0);
            access(1'b1, AW'(a), 32'hFFFF_FFFF);
            chk("R2 write rsp", r_rsp, 1);
        end
        chk_tbl("R2");
        access(1'b0, 8'h00, 0);
        chk("R2 select untouched", r_data, 0);

        // R3: select limits
        access(1'b1, 8'h00, 32'h2A);
        chk("R3 accept rsp", r_rsp, 0);
        access(1'b1, 8'h00, 32'h100);
        chk("R3 invalid rsp", r_rsp, 2);
        chk("R3 invalid data", r_data, 0);
        access(1'b0, 8'h00, 0);
        chk("R3 select kept", r_data, 32'h2A);
        access(1'b1, 8'h00, 32'hFF);
        access(1'b0, 8'h00, 0);
        chk("R3 select 0xFF", r_data, 32'hFF);

        // R4: identification word
        access(1'b1, 8'h00, 32'h00);
        access(1'b1, 8'h10, 32'hDEAD_BEEF);
        m_id = 32'hDEAD_BEEF;
        chk("R4 write rsp", r_rsp, 0);
        chk("R10 write data zero", r_data, 0);
        access(1'b0, 8'h10, 0);
        chk("R4 id read", r_data, m_id);
        @(negedge clk);
        chk("R10 hold data", bus_rdata, m_id);
        chk("R10 hold rsp", bus_rsp, 0);

        // R5, R6, R7: read-only words
        access(1'b1, 8'h00, 32'h01);
        access(1'b0, 8'h10, 0);
        chk("R5 version", r_data, (32'(N - 1) << 16) | 32'h11);
        access(1'b1, 8'h10, 32'hFFFF_FFFF);
        chk("R7 ver write rsp", r_rsp, 0);
        access(1'b0, 8'h10, 0);
        chk("R7 version unchanged", r_data, (32'(N - 1) << 16) | 32'h11);
        access(1'b1, 8'h00, 32'h02);
        access(1'b0, 8'h10, 0);
        chk("R6 arbitration", r_data, 0);
        access(1'b1, 8'h10, 32'h1234_5678);
        chk("R7 arb write rsp", r_rsp, 0);
        access(1'b0, 8'h10, 0);
        chk("R7 arbitration unchanged", r_data, 0);
        chk_tbl("R7");

        // R8, R11: fill every table half
        for (int s = 16; s < 16 + 2 * N; s++) begin
            access(1'b1, 8'h00, 32'(s));
            access(1'b1, 8'h10, pat(s));
            chk("R8 write rsp", r_rsp, 0);
            if ((s - 16) % 2 == 1) m_hi[(s - 16) / 2] = pat(s);
            else m_lo[(s - 16) / 2] = pat(s);
            chk_tbl("R11 after write");
        end

        // R9: writes to unsupported indices
        for (int s = 3; s < 256; s++) begin
            if (exp_rsp(s) == 2'd0) continue;
            access(1'b1, 8'h00, 32'(s));
            access(1'b1, 8'h10, 32'hA5A5_A5A5);
            chk("R9 write rsp", r_rsp, 1);
        end
        chk_tbl("R9");

        // R8, R9: read sweep of every window index
        for (int s = 0; s < 256; s++) begin
            access(1'b1, 8'h00, 32'(s));
            access(1'b0, 8'h10, 0);
            chk("R8/R9 window rsp", r_rsp, exp_rsp(s));
            chk("R8/R9 window data", r_data, exp_win(s));
        end

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk_tbl("R1 rerun");
        access(1'b0, 8'h00, 0);
        chk("R1 select rerun", r_data, 0);
        access(1'b0, 8'h10, 0);
        chk("R1 id rerun", r_data, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule